// File: doc/BRIEF.md
# Single-precision to bfloat16 rounding converter

This block narrows a 32-bit IEEE single-precision word to bfloat16. The result sits in the upper half of a 32-bit output word, and the lower half of that word is always zero. Because of this placement, two results can later be packed into one word by shifting one of them.

Ordinary values keep their sign and exponent. The 23-bit mantissa is rounded to 7 fraction bits by adding half of the lowest kept bit. There is no tie-to-even step. When rounding carries out of the mantissa, the value is renormalised by bumping the exponent. Words whose exponent field is all ones (infinity and NaN) bypass rounding and are truncated. Signed zeros bypass rounding in the same way.

A parameter selects the timing variant:
- **Registered:** the result is captured one clock after an input strobe, and a one-cycle output valid is raised.
- **Combinational:** the result and the valid follow the inputs directly.

Top module: `bf16_round_conv`

## Requirements
- R1: While reset is asserted (active low) and after its release with no strobe, out_word is 0x00000000 and out_valid is 0.
- R2: With REGISTERED=1, a cycle with in_valid=1 makes out_valid 1 and loads out_word on the next clock edge. In a cycle after a cycle with in_valid=0, out_valid is 0 and out_word holds its previous value.
- R3: Bits 15..0 of out_word are always zero.
- R4: Bit 31 of out_word equals bit 31 of the converted input word.
- R5: If input bits 30..23 are all ones (infinity or NaN), out_word is input bits 31..16 followed by 16 zero bits, with no rounding. For example, 0x7FC01234 gives 0x7FC00000 and 0x7F80FFFF gives 0x7F800000.
- R6: If input bits 30..0 are all zero, out_word is {input bit 31, 31 zero bits}.
- R7: Otherwise the 24-bit significand {1, bits 22..0} is added to 0x8000. If the sum has no bit 24, bits 22..16 of the sum become out_word bits 22..16, and the input exponent (bits 30..23) is kept.
- R8: If that sum sets bit 24, the exponent is incremented by one and the fraction is sum bits 23..17. For example, 0x3FFFFFFF gives 0x40000000 and 0x3FFF8000 gives 0x40000000, while 0x3FFF7FFF gives 0x3FFF0000.
- R9: Rounding the largest finite magnitude is not saturated. 0x7F7FFFFF gives 0x7F800000 (infinity).
- R10: An input with exponent field zero and a nonzero mantissa follows the R7/R8 rule, with the implicit 1 inserted. For example, 0x0000FFFF gives 0x00010000.
- R11: With REGISTERED=0, out_word is the converted in_word in the same cycle and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Single-precision input |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | bfloat16 result in bits 31..16, zeros below |

## Verification
In the registered variant, out_word and out_valid are due one clock edge after the strobe cycle. The bench drives a strobe at a falling edge and samples at the next falling edge, after exactly one rising edge. It then drops the strobe, changes in_word, and samples one more falling edge later to confirm that out_valid has fallen and out_word has held. A second, combinational instance shares the same inputs and is sampled 1 ns after each input change, within the same cycle.

// File: rtl/bf16_round_conv.sv
module bf16_round_conv #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [31:0] out_word
);

  logic        is_special;
  logic [24:0] rnd_sum;
  logic        carry;
  logic [7:0]  exp_adj;
  logic [6:0]  frac;
  logic [31:0] conv;

  assign is_special = (&in_word[30:23]) | (in_word[30:0] == 31'd0);
  assign rnd_sum    = {1'b0, 1'b1, in_word[22:0]} + 25'h0008000;
  assign carry      = rnd_sum[24];
  assign exp_adj    = in_word[30:23] + {7'd0, carry};
  assign frac       = carry ? rnd_sum[23:17] : rnd_sum[22:16];
  assign conv       = is_special ? {in_word[31:16], 16'h0000}
                                 : {in_word[31], exp_adj, frac, 16'h0000};

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_word  <= 32'd0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_word <= conv;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_word  = conv;
    end
  endgenerate

endmodule

// File: rtl/bf16_round_conv_chk.sv
module bf16_round_conv_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [31:0] out_word
);

  // R3
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[15:0] == 16'h0000);

  generate
    if (REGISTERED) begin : g_reg_chk
      // R2
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R2
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R2
      hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
      // R4
      sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[31] == $past(in_word[31]));
      // R5
      special_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_word[30:23])) |=> out_word[31:16] == $past(in_word[31:16]));
      // R6
      zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[30:0] == 31'd0) |=> out_word == {$past(in_word[31]), 31'd0});
    end else begin : g_comb_chk
      // R11
      comb_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
    end
  endgenerate

endmodule

bind bf16_round_conv bf16_round_conv_chk #(.REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_word(out_word)
);

// File: tb/bf16_round_conv_test.sv
`timescale 1ns/1ps
module bf16_round_conv_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = 32'd0;
  logic        out_valid, c_valid;
  logic [31:0] out_word, c_word;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bf16_round_conv #(.REGISTERED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word));

  bf16_round_conv #(.REGISTERED(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(c_valid), .out_word(c_word));

  // R7 rounding vectors: {input, expected}
  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {32'h4141F9A7, 32'h41420000},
    {32'h3FA66666, 32'h3FA60000},
    {32'h43E43A5E, 32'h43E40000},
    {32'h423645A2, 32'h42360000},
    {32'h3F808000, 32'h3F810000},
    {32'h3F807FFF, 32'h3F800000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] din, input logic [31:0] dexp);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = din;
    #1;
    check({tag, " R11 comb word"}, c_word, dexp);
    check("R11 comb valid", {31'd0, c_valid}, 32'd1);
    @(negedge clk);
    check(tag, out_word, dexp);
    check("R2 valid after strobe", {31'd0, out_valid}, 32'd1);
    check("R3 low half", {16'd0, out_word[15:0]}, 32'd0);
    check("R4 sign", {31'd0, out_word[31]}, {31'd0, din[31]});
    in_valid = 1'b0;
    in_word  = ~din;
    @(negedge clk);
    check("R2 valid dropped", {31'd0, out_valid}, 32'd0);
    check("R2 word held", out_word, dexp);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #7;
    check("R1 reset word", out_word, 32'd0);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle word", out_word, 32'd0);
    check("R1 idle valid", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run("R7", VEC[i][63:32], VEC[i][31:0]);

    run("R8 carry", 32'h3FFFFFFF, 32'h40000000);
    run("R8 carry edge", 32'h3FFF8000, 32'h40000000);
    run("R8 no carry edge", 32'h3FFF7FFF, 32'h3FFF0000);
    run("R8 negative carry", 32'hBFFFFFFF, 32'hC0000000);
    run("R9 overflow", 32'h7F7FFFFF, 32'h7F800000);
    run("R10 subnormal", 32'h0000FFFF, 32'h00010000);
    run("R10 subnormal half", 32'h00400000, 32'h00400000);
    run("R5 +inf", 32'h7F800000, 32'h7F800000);
    run("R5 -inf", 32'hFF800000, 32'hFF800000);
    run("R5 nan", 32'h7FC01234, 32'h7FC00000);
    run("R5 nan low", 32'h7F80FFFF, 32'h7F800000);
    run("R6 +zero", 32'h00000000, 32'h00000000);
    run("R6 -zero", 32'h80000000, 32'h80000000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule